// File: doc/BRIEF.md
# Nine-Bit Addressable Serial Receiver

This block receives asynchronous serial frames eleven bits long: one start bit, eight data bits sent least-significant first, a ninth data bit, and one stop bit. The line is read on a clock enable that pulses sixteen times per bit period. A falling edge on the idle line starts a frame and resets the tick counter. Each bit is sampled three times near the middle of its period, and the bit value is the majority of those three samples.

When the frame reaches its decision point, the byte and the ninth bit are copied into holding registers and a receive flag is raised. This happens only if the receive flag is still clear from the previous frame, and only if either address filtering is off or the ninth bit is 1. Any other frame is dropped without a trace. With filtering on, a multidrop slave sees only address frames until it chooses to listen to data.

A mode input moves the decision point. It is normally the stop-bit sample. In early mode it is the sample of the ninth data bit. A stop bit sampled as 0 sets a sticky framing-error flag.

Top module: `mpr_rx_top`

## Requirements
- R1: After reset the receiver is idle, and rx_data, rx_bit9, rx_irq and frame_err all read 0.
- R2: An accepted frame puts its eight data bits into rx_data, with the first bit received in bit 0. The ninth bit received goes into rx_bit9. rx_irq then reads 1.
- R3: Each bit is the majority of the line samples taken at ticks 7, 8 and 9 of its period. A wrong level on a single one of those ticks does not change the bit.
- R4: If the start bit votes 1, the receiver returns to idle. rx_data, rx_bit9 and rx_irq are left unchanged, and the next frame is received normally.
- R5: A frame that reaches its decision point while rx_irq is 1 is dropped. rx_data, rx_bit9 and rx_irq keep their values.
- R6: While addr_filt is 1, a frame whose ninth bit is 0 is dropped and a frame whose ninth bit is 1 is accepted. While addr_filt is 0, frames are accepted whatever their ninth bit.
- R7: frame_err becomes 1 when the stop bit votes 0. It stays 1 until fe_clr is pulsed. A set in the same cycle as fe_clr wins.
- R8: Pulsing ri_clr drops rx_irq to 0. If a frame is accepted in the same cycle, rx_irq reads 1 in the following cycle.
- R9: When early_irq is 1, the decision (acceptance, load and rx_irq) happens at the sample of the ninth data bit, before the stop bit. When early_irq is 0, it happens at the stop-bit sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Clock enable, sixteen pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| addr_filt | input | 1 | Accept only frames whose ninth bit is 1 |
| early_irq | input | 1 | Decide at the ninth-bit sample instead of the stop sample |
| ri_clr | input | 1 | Clear strobe for rx_irq |
| fe_clr | input | 1 | Clear strobe for frame_err |
| rx_data | output | 8 | Received byte |
| rx_bit9 | output | 1 | Received ninth bit |
| rx_irq | output | 1 | Receive flag |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
Random frames mix byte values, ninth-bit values, filter settings, and whether the flag is cleared before each frame. Together they separate the accept path from the two drop paths: a filtered non-address frame, and any frame arriving while the flag is pending. Directed frames cover the rest. A start pulse too short to pass the vote tests glitch rejection. A single corrupted tick inside a data bit shows whether the majority vote is used. A zero stop bit and a later clear test the sticky error flag. Holding the clear strobe across a frame shows set-over-clear priority. Probing the flag early in the stop bit tells early decision apart from normal decision.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int unsigned OVS     = 16;
  localparam int unsigned CNT_W   = $clog2(OVS);
  localparam int unsigned SMP_MID = 8;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRM_W   = DATA_W + 1;
  localparam int unsigned IDX_W   = $clog2(FRM_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/mpr_sampler.sv
module mpr_sampler
  import mpr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             rxd,
  input  logic [CNT_W-1:0] cnt,
  output logic             line,
  output logic             vote
);
  logic [1:0] sync_q;
  logic       s_lo_q, s_mid_q;
  logic       s_lo_d, s_mid_d;

  assign line = sync_q[1];

  always_comb begin
    s_lo_d  = s_lo_q;
    s_mid_d = s_mid_q;
    if (tick16 && cnt == CNT_W'(SMP_MID - 1)) s_lo_d  = line;
    if (tick16 && cnt == CNT_W'(SMP_MID))     s_mid_d = line;
  end

  assign vote = (s_lo_q & s_mid_q) | (s_lo_q & line) | (s_mid_q & line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      s_lo_q  <= 1'b1;
      s_mid_q <= 1'b1;
    end else begin
      sync_q  <= {sync_q[0], rxd};
      s_lo_q  <= s_lo_d;
      s_mid_q <= s_mid_d;
    end
  end
endmodule

// File: rtl/mpr_framer.sv
module mpr_framer
  import mpr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             line,
  input  logic             vote,
  input  logic             early_irq,
  output logic [CNT_W-1:0] cnt,
  output logic             dec_evt,
  output logic [FRM_W-1:0] dec_word,
  output logic             stop_evt,
  output logic             stop_bad
);
  rx_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [FRM_W-1:0] sh_q, sh_d;
  logic             prev_q, prev_d;
  logic             at_vote, at_end, last_bit;

  assign cnt      = cnt_q;
  assign at_vote  = tick16 && cnt_q == CNT_W'(SMP_MID + 1);
  assign at_end   = tick16 && cnt_q == CNT_W'(OVS - 1);
  assign last_bit = idx_q == IDX_W'(FRM_W - 1);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    prev_d   = tick16 ? line : prev_q;
    dec_evt  = 1'b0;
    dec_word = sh_q;
    stop_evt = 1'b0;
    stop_bad = 1'b0;
    if (tick16 && st_q != ST_IDLE) cnt_d = cnt_q + 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        if (tick16 && prev_q && !line) begin
          st_d  = ST_START;
          cnt_d = '0;
        end
      end
      ST_START: begin
        if (at_vote && vote) st_d = ST_IDLE;
        else if (at_end) begin
          st_d  = ST_DATA;
          idx_d = '0;
        end
      end
      ST_DATA: begin
        if (at_vote) begin
          sh_d  = {vote, sh_q[FRM_W-1:1]};
          idx_d = idx_q + 1'b1;
          if (last_bit && early_irq) begin
            dec_evt  = 1'b1;
            dec_word = sh_d;
          end
        end
        if (at_end && idx_q == IDX_W'(FRM_W)) st_d = ST_STOP;
      end
      ST_STOP: begin
        if (at_vote) begin
          stop_evt = 1'b1;
          stop_bad = !vote;
          dec_evt  = !early_irq;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      prev_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/mpr_holder.sv
module mpr_holder
  import mpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_evt,
  input  logic [FRM_W-1:0]  dec_word,
  input  logic              stop_evt,
  input  logic              stop_bad,
  input  logic              addr_filt,
  input  logic              ri_clr,
  input  logic              fe_clr,
  output logic              load_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_irq,
  output logic              frame_err
);
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              b9_q, b9_d, ri_q, ri_d, fe_q, fe_d;

  assign load_en = dec_evt && !ri_q && (!addr_filt || dec_word[FRM_W-1]);

  always_comb begin
    dat_d = dat_q;
    b9_d  = b9_q;
    ri_d  = ri_q;
    fe_d  = fe_q;
    if (load_en) begin
      dat_d = dec_word[DATA_W-1:0];
      b9_d  = dec_word[FRM_W-1];
      ri_d  = 1'b1;
    end else if (ri_clr) begin
      ri_d = 1'b0;
    end
    if (stop_evt && stop_bad) fe_d = 1'b1;
    else if (fe_clr)          fe_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      b9_q  <= 1'b0;
      ri_q  <= 1'b0;
      fe_q  <= 1'b0;
    end else begin
      dat_q <= dat_d;
      b9_q  <= b9_d;
      ri_q  <= ri_d;
      fe_q  <= fe_d;
    end
  end

  assign rx_data   = dat_q;
  assign rx_bit9   = b9_q;
  assign rx_irq    = ri_q;
  assign frame_err = fe_q;
endmodule

// File: rtl/mpr_rx_top.sv
module mpr_rx_top
  import mpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              addr_filt,
  input  logic              early_irq,
  input  logic              ri_clr,
  input  logic              fe_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_irq,
  output logic              frame_err
);
  logic [CNT_W-1:0] cnt;
  logic             line, vote, dec_evt, stop_evt, stop_bad, load_en;
  logic [FRM_W-1:0] dec_word;

  mpr_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cnt(cnt), .line(line), .vote(vote)
  );

  mpr_framer u_frm (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .line(line), .vote(vote),
    .early_irq(early_irq), .cnt(cnt), .dec_evt(dec_evt), .dec_word(dec_word),
    .stop_evt(stop_evt), .stop_bad(stop_bad)
  );

  mpr_holder u_hld (
    .clk(clk), .rst_n(rst_n), .dec_evt(dec_evt), .dec_word(dec_word),
    .stop_evt(stop_evt), .stop_bad(stop_bad), .addr_filt(addr_filt),
    .ri_clr(ri_clr), .fe_clr(fe_clr), .load_en(load_en),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_irq(rx_irq), .frame_err(frame_err)
  );
endmodule

// File: rtl/mpr_rx_chk.sv
module mpr_rx_chk
  import mpr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              addr_filt,
  input logic              fe_clr,
  input logic              load_en,
  input logic              dec_evt,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_bit9,
  input logic              rx_irq,
  input logic              frame_err
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(rx_data) && $stable(rx_bit9)); // R5
  AST_DROP_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    dec_evt && rx_irq |=> $stable(rx_data)); // R5
  AST_FILTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && addr_filt |=> rx_bit9); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> rx_irq); // R8
  AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err && !fe_clr |=> frame_err); // R7
endmodule

bind mpr_rx_top mpr_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_filt(addr_filt), .fe_clr(fe_clr),
  .load_en(load_en), .dec_evt(dec_evt), .rx_data(rx_data), .rx_bit9(rx_bit9),
  .rx_irq(rx_irq), .frame_err(frame_err)
);

// File: tb/tb_mpr_rx_top.sv
module tb_mpr_rx_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic       addr_filt = 1'b0, early_irq = 1'b0, ri_clr = 1'b0, fe_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_irq, frame_err;
  int         n_chk = 0, n_err = 0;
  logic [1:0] ph = 2'd0;
  logic [7:0] m_dat = 8'h00;
  logic       m_b9 = 1'b0, m_ri = 1'b0;
  logic       mon_en = 1'b0;
  int         seen = 0;

  mpr_rx_top dut (.*);

  always #4 clk = ~clk;

  always @(negedge clk) begin
    ph     <= ph + 2'd1;
    tick16 <= (ph == 2'd3);
    if (mon_en && rx_irq) seen++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic bitv(input logic v);
    rxd = v;
    wt(16);
  endtask

  function automatic logic accept(input logic ri, input logic f, input logic b9);
    return !ri && (!f || b9);
  endfunction

  task automatic send(input logic [7:0] d, input logic b9, input logic sp);
    bitv(1'b0);
    for (int i = 0; i < 8; i++) bitv(d[i]);
    bitv(b9);
    bitv(sp);
    rxd = 1'b1;
    wt(6);
  endtask

  task automatic model(input logic [7:0] d, input logic b9);
    if (accept(m_ri, addr_filt, b9)) begin
      m_dat = d; m_b9 = b9; m_ri = 1'b1;
    end
  endtask

  task automatic clr_ri();
    @(negedge clk) ri_clr = 1'b1;
    @(negedge clk) ri_clr = 1'b0;
    m_ri = 1'b0;
  endtask

  task automatic cmp(input string tag);
    chk({tag, " data"}, rx_data, m_dat);
    chk({tag, " bit9"}, rx_bit9, m_b9);
    chk({tag, " irq"}, rx_irq, m_ri);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (5) @(negedge clk);
    chk("R1 data", rx_data, 0);
    chk("R1 bit9", rx_bit9, 0);
    chk("R1 irq", rx_irq, 0);
    chk("R1 fe", frame_err, 0);
    rst_n = 1'b1;
    wt(20);

    // R2: plain frame, no filter
    send(8'hA5, 1'b0, 1'b1); model(8'hA5, 1'b0); cmp("R2");
    // R5: flag still pending, frame dropped
    send(8'h3C, 1'b1, 1'b1); model(8'h3C, 1'b1); cmp("R5");
    clr_ri(); chk("R8 clear", rx_irq, 0);

    // R6: filter drops non-address, takes address
    addr_filt = 1'b1;
    send(8'h11, 1'b0, 1'b1); model(8'h11, 1'b0); cmp("R6 drop");
    send(8'h82, 1'b1, 1'b1); model(8'h82, 1'b1); cmp("R6 take");
    clr_ri(); addr_filt = 1'b0;

    // R4: short start pulse rejected, next frame normal
    rxd = 1'b0; wt(3); rxd = 1'b1; wt(30);
    cmp("R4 glitch");
    send(8'h5A, 1'b1, 1'b1); model(8'h5A, 1'b1); cmp("R4 after");
    clr_ri();

    // R3: one wrong tick inside the sample window of D3
    bitv(1'b0);
    for (int i = 0; i < 8; i++) begin
      if (i == 3) begin rxd = 1'b1; wt(9); rxd = 1'b0; wt(1); rxd = 1'b1; wt(6); end
      else bitv(8'h0F >> i);
    end
    bitv(1'b0); bitv(1'b1); wt(6);
    model(8'h0F, 1'b0); cmp("R3 vote");
    clr_ri();

    // R7: bad stop bit, sticky, cleared by strobe
    send(8'h77, 1'b1, 1'b0); model(8'h77, 1'b1);
    chk("R7 set", frame_err, 1); cmp("R7 frame");
    clr_ri();
    send(8'h12, 1'b0, 1'b1); model(8'h12, 1'b0);
    chk("R7 sticky", frame_err, 1);
    @(negedge clk) fe_clr = 1'b1;
    @(negedge clk) fe_clr = 1'b0;
    chk("R7 cleared", frame_err, 0);
    clr_ri();

    // R8: clear held across acceptance, set wins for a cycle
    ri_clr = 1'b1; seen = 0; mon_en = 1'b1;
    send(8'hC3, 1'b1, 1'b1);
    mon_en = 1'b0; ri_clr = 1'b0;
    chk("R8 set wins", seen > 0, 1);
    chk("R8 data", rx_data, 8'hC3);
    chk("R8 irq after clear", rx_irq, 0);
    m_dat = 8'hC3; m_b9 = 1'b1; m_ri = 1'b0;

    // R9: probe flag early in stop bit, both modes
    for (int e = 0; e < 2; e++) begin
      early_irq = e[0];
      bitv(1'b0);
      for (int i = 0; i < 8; i++) bitv(8'h69 >> i);
      bitv(1'b1);
      rxd = 1'b1; wt(4);
      chk(e ? "R9 early irq" : "R9 normal irq", rx_irq, e);
      wt(18);
      model(8'h69, 1'b1); cmp("R9 end");
      clr_ri();
    end
    early_irq = 1'b0;

    // R2 R5 R6: random frames
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d;
      logic b9;
      d = 8'($urandom());
      b9 = 1'($urandom());
      addr_filt = 1'($urandom());
      if ($urandom() % 2 == 0) clr_ri();
      send(d, b9, 1'b1);
      model(d, b9);
      cmp("R2/R5/R6 rand");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule